// File: doc/BRIEF.md
# Horizontal Line Segment Sequencer

This block walks one video scan line pixel by pixel. Each cycle in which the pixel enable is high counts as one pixel. The line runs through six segments in a fixed order: sync, left blanking, left border, active display, right border and right blanking. After the last pixel of right blanking, the line starts again at the first sync pixel.

A two-bit mode input chooses one of four sets of segment lengths. Each set has its own uneven split of the line. The mode is captured when the block leaves reset and again each time a line wraps. Because of this, a change of mode partway through a line never gives a line that mixes two modes.

The outputs are an active-low horizontal sync, three region flags (blank, border, active) and the pixel index inside the active area. A single-cycle line-end strobe drives the vertical sequencer that comes after this block. The outputs decode the current pixel with no extra delay, and the line-end strobe follows the pixel enable in the same cycle.

Top module: `hline_seq`

## Requirements
- R1: While reset is high, and after it is released with no pixel enable, the block sits on line pixel 0. At that pixel `hsyncN`=0, `blank`=1, `border`=0, `active`=0, `xPos`=0 and `lineEnd`=0.
- R2: With `mode`=2'b00 (256 wide), the segment lengths in pixels are: sync 26, left blank 25, left border 14, active 256, right border 14, right blank 7. The line is 342 pixels.
- R3: With `mode`=2'b01 (320 wide, external pixel clock), the segment lengths are: sync 34, left blank 30, left border 13, active 320, right border 14, right blank 9. The line is 420 pixels.
- R4: With `mode`=2'b10 (320 wide, internal pixel clock), the segment lengths are: sync 32, left blank 32, left border 13, active 320, right border 14, right blank 9. The line is 420 pixels.
- R5: With `mode`=2'b11 (legacy compatibility), the segment lengths are: sync 26, left blank 24, left border 14, active 256, right border 14, right blank 8. The line is 342 pixels.
- R6: `hsyncN` is 0 during every sync pixel and 1 on every other pixel.
- R7: `blank` is 1 during sync and both blanking segments. `border` is 1 during both border segments. `active` is 1 during active display. Exactly one of the three flags is 1 on every pixel.
- R8: During active display, `xPos` equals the index of the pixel within the active segment, starting from 0. From the start of a line until active display begins, `xPos` reads 0.
- R9: `lineEnd` is 1 only in a cycle where `pixEn`=1 and the current pixel is the last pixel of right blanking. The pixel that follows is line pixel 0, the first sync pixel.
- R10: A cycle with `pixEn`=0 leaves the position unchanged, so every output holds its value, and `lineEnd` stays 0.
- R11: `mode` is sampled in reset and on the line wrap. A change of `mode` during a line has no effect until the next line starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pixEn | input | 1 | One pixel advances on each cycle where this is high |
| mode | input | 2 | Selects the segment-length set (see R2 to R5) |
| hsyncN | output | 1 | Horizontal sync, active low |
| blank | output | 1 | Sync or blanking segment |
| border | output | 1 | Left or right border segment |
| active | output | 1 | Active display segment |
| xPos | output | POS_W | Pixel index within the active display |
| lineEnd | output | 1 | One-cycle strobe on the last pixel of the line |

## Verification
Every mode is swept over whole lines twice. The first sweep holds the pixel enable high continuously, which checks each segment boundary and the line length. The second sweep stalls the enable on one cycle in three. This separates a sequencer that counts pixels from one that counts clocks, and it confirms that stalled cycles hold the outputs and suppress the line-end strobe. The mode input is also changed partway through a line, which shows whether the lengths are latched at the line wrap or followed live. A reset partway through a line checks that the block returns to the first sync pixel.

// File: rtl/hline_pkg.sv
package hline_pkg;

  parameter int LEN_W = 9;

  typedef enum logic [2:0] {
    SEG_SYNC    = 3'd0,
    SEG_LBLANK  = 3'd1,
    SEG_LBORDER = 3'd2,
    SEG_ACTIVE  = 3'd3,
    SEG_RBORDER = 3'd4,
    SEG_RBLANK  = 3'd5
  } seg_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic adv;     // a pixel is consumed this cycle
    logic actAdv;  // an active-display pixel is consumed
    logic wrap;    // last pixel of the line is consumed
  } strobe_t;

  function automatic logic [LEN_W-1:0] segLen(input logic [1:0] mode, input seg_e seg);
    logic [LEN_W-1:0] r;
    r = '0;
    case (mode)
      2'b00: case (seg)
        SEG_SYNC: r = 9'd26;  SEG_LBLANK: r = 9'd25;  SEG_LBORDER: r = 9'd14;
        SEG_ACTIVE: r = 9'd256; SEG_RBORDER: r = 9'd14; default: r = 9'd7;
      endcase
      2'b01: case (seg)
        SEG_SYNC: r = 9'd34;  SEG_LBLANK: r = 9'd30;  SEG_LBORDER: r = 9'd13;
        SEG_ACTIVE: r = 9'd320; SEG_RBORDER: r = 9'd14; default: r = 9'd9;
      endcase
      2'b10: case (seg)
        SEG_SYNC: r = 9'd32;  SEG_LBLANK: r = 9'd32;  SEG_LBORDER: r = 9'd13;
        SEG_ACTIVE: r = 9'd320; SEG_RBORDER: r = 9'd14; default: r = 9'd9;
      endcase
      default: case (seg)
        SEG_SYNC: r = 9'd26;  SEG_LBLANK: r = 9'd24;  SEG_LBORDER: r = 9'd14;
        SEG_ACTIVE: r = 9'd256; SEG_RBORDER: r = 9'd14; default: r = 9'd8;
      endcase
    endcase
    return r;
  endfunction

  function automatic logic [LEN_W-1:0] lineLen(input logic [1:0] mode);
    logic [LEN_W-1:0] s;
    s = '0;
    for (int k = 0; k < 6; k++) s = s + segLen(mode, seg_e'(k[2:0]));
    return s;
  endfunction

endpackage

// File: rtl/hline_ctrl.sv
module hline_ctrl
  import hline_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pixEn,
  input  logic [1:0] mode,
  output logic [1:0] modeQ,
  output strobe_t    stb,
  output logic       hsyncN,
  output logic       blank,
  output logic       border,
  output logic       active,
  output logic       lineEnd
);

  seg_e             seg;
  logic [LEN_W-1:0] segCnt;
  logic [LEN_W-1:0] curLen;
  logic             lastPix;

  assign curLen  = segLen(modeQ, seg);
  assign lastPix = (segCnt >= curLen - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      seg    <= SEG_SYNC;
      segCnt <= '0;
      modeQ  <= mode;
    end else if (pixEn) begin
      if (lastPix) begin
        segCnt <= '0;
        if (seg == SEG_RBLANK) begin
          seg   <= SEG_SYNC;
          modeQ <= mode;
        end else begin
          seg <= seg_e'(seg + 3'd1);
        end
      end else begin
        segCnt <= segCnt + 1'b1;
      end
    end
  end

  assign lineEnd    = pixEn && (seg == SEG_RBLANK) && lastPix;
  assign stb.adv    = pixEn;
  assign stb.actAdv = pixEn && (seg == SEG_ACTIVE);
  assign stb.wrap   = lineEnd;

  always_comb begin
    hsyncN = (seg != SEG_SYNC);
    blank  = (seg == SEG_SYNC) || (seg == SEG_LBLANK) || (seg == SEG_RBLANK);
    border = (seg == SEG_LBORDER) || (seg == SEG_RBORDER);
    active = (seg == SEG_ACTIVE);
  end

  // R6
  sync_in_blank_chk: assert property (@(posedge clk) disable iff (rst) !hsyncN |-> blank);

  // R7
  one_flag_chk: assert property (@(posedge clk) disable iff (rst) $countones({blank, border, active}) == 1);

  // R9
  wrap_to_sync_chk: assert property (@(posedge clk) disable iff (rst)
    lineEnd |=> (seg == SEG_SYNC) && (segCnt == '0));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pixEn |=> $stable(seg) && $stable(segCnt));

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst) !lineEnd |=> $stable(modeQ));

endmodule

// File: rtl/hline_dp.sv
module hline_dp
  import hline_pkg::*;
#(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          stb,
  input  logic [1:0]       modeQ,
  output logic [POS_W-1:0] xPos
);

  localparam int ACT_MAX = 320;

  logic [LEN_W-1:0] lineCnt;
  logic [LEN_W-1:0] curLine;

  assign curLine = lineLen(modeQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      xPos    <= '0;
      lineCnt <= '0;
    end else begin
      if (stb.wrap) begin
        xPos    <= '0;
        lineCnt <= '0;
      end else begin
        if (stb.actAdv) xPos <= xPos + 1'b1;
        if (stb.adv) lineCnt <= lineCnt + 1'b1;
      end
    end
  end

  // R9
  line_len_chk: assert property (@(posedge clk) disable iff (rst)
    stb.wrap |-> (lineCnt == curLine - 1'b1));

  // R8
  act_range_chk: assert property (@(posedge clk) disable iff (rst)
    stb.actAdv |-> (int'(xPos) < ACT_MAX));

endmodule

// File: rtl/hline_seq.sv
module hline_seq
  import hline_pkg::*;
#(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pixEn,
  input  logic [1:0]       mode,
  output logic             hsyncN,
  output logic             blank,
  output logic             border,
  output logic             active,
  output logic [POS_W-1:0] xPos,
  output logic             lineEnd
);

  strobe_t    stb;
  logic [1:0] modeQ;

  hline_ctrl u_ctrl (
    .clk(clk), .rst(rst), .pixEn(pixEn), .mode(mode), .modeQ(modeQ), .stb(stb),
    .hsyncN(hsyncN), .blank(blank), .border(border), .active(active), .lineEnd(lineEnd)
  );

  hline_dp #(.POS_W(POS_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .modeQ(modeQ), .xPos(xPos)
  );

endmodule

// File: tb/hline_seq_tb.sv
`timescale 1ns/1ps
module hline_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pixEn = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       hsyncN, blank, border, active, lineEnd;
  logic [8:0] xPos;

  int vectors = 0;
  int errors = 0;
  int p = 0;        // model line pixel
  int mq = 0;       // model latched mode

  always #4 clk = ~clk;

  hline_seq #(.POS_W(9)) u_dut (
    .clk(clk), .rst(rst), .pixEn(pixEn), .mode(mode), .hsyncN(hsyncN), .blank(blank),
    .border(border), .active(active), .xPos(xPos), .lineEnd(lineEnd)
  );

  function automatic int len(int m, int k);
    int a[6];
    case (m)
      0: a = '{26, 25, 14, 256, 14, 7};
      1: a = '{34, 30, 13, 320, 14, 9};
      2: a = '{32, 32, 13, 320, 14, 9};
      default: a = '{26, 24, 14, 256, 14, 8};
    endcase
    return a[k];
  endfunction

  function automatic int total(int m);
    int s = 0;
    for (int k = 0; k < 6; k++) s += len(m, k);
    return s;
  endfunction

  function automatic string modeTag(int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input logic pe, input string extra);
    int k, off, acc;
    logic eH, eB, eBo, eA, eL;
    int eX;
    logic bad;
    string tg;
    acc = 0; k = 0;
    for (int j = 0; j < 6; j++) begin
      if (p >= acc && p < acc + len(mq, j)) begin k = j; off = p - acc; end
      acc += len(mq, j);
    end
    eH  = (k != 0);
    eB  = (k == 0 || k == 1 || k == 5);
    eBo = (k == 2 || k == 4);
    eA  = (k == 3);
    eL  = pe && (p == total(mq) - 1);
    eX  = (k == 3) ? off : 0;
    tg  = pe ? modeTag(mq) : "R10";
    bad = 1'b0;
    vectors++;
    if (hsyncN !== eH) begin
      $display("FAIL R6 %s %s pix %0d hsyncN act %b exp %b", tg, extra, p, hsyncN, eH); bad = 1'b1;
    end
    if ({blank, border, active} !== {eB, eBo, eA}) begin
      $display("FAIL R7 %s %s pix %0d flags act %b exp %b", tg, extra, p,
               {blank, border, active}, {eB, eBo, eA}); bad = 1'b1;
    end
    if (k <= 3 && int'(xPos) !== eX) begin
      $display("FAIL R8 %s %s pix %0d xPos act %0d exp %0d", tg, extra, p, xPos, eX); bad = 1'b1;
    end
    if (lineEnd !== eL) begin
      $display("FAIL R9 %s %s pix %0d lineEnd act %b exp %b", tg, extra, p, lineEnd, eL); bad = 1'b1;
    end
    if (bad) errors++;
  endtask

  task automatic step(input logic pe, input string extra);
    @(negedge clk);
    pixEn = pe;
    #1;
    check(pe, extra);
    @(posedge clk);
    if (pe) begin
      if (p == total(mq) - 1) begin p = 0; mq = int'(mode); end
      else p++;
    end
  endtask

  task automatic doReset(input logic [1:0] m);
    @(negedge clk);
    pixEn = 1'b0; mode = m; rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    p = 0; mq = int'(m);
    step(1'b0, "R1 reset");
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired act running exp done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int m = 0; m < 4; m++) begin
      doReset(m[1:0]);                      // R1
      for (int i = 0; i < 2 * total(m) + 3; i++) step(1'b1, "run");
      for (int i = 0; i < 3 * total(m) / 2 + 10; i++) step((i % 3) != 1, "gap");  // R10
    end
    // R11: mode change in the middle of a line waits for the wrap
    doReset(2'b00);
    for (int i = 0; i < 100; i++) step(1'b1, "R11 pre");
    mode = 2'b01;
    for (int i = 0; i < 342 + 430; i++) step(1'b1, "R11 post");
    mode = 2'b11;
    for (int i = 0; i < 200; i++) step(1'b1, "R11 back");
    // R1: reset in the middle of a line
    @(negedge clk);
    rst = 1'b1; pixEn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    p = 0; mq = int'(mode);
    step(1'b0, "R1 midline");
    for (int i = 0; i < 400; i++) step(1'b1, "R1 after");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule